// File: doc/BRIEF.md
# Auto-Incrementing Calibration Register Bank

This block holds the trim words of a converter front end: one gain word, one offset word and eight DAC trim words, each 14 bits wide. A host reaches all of them through one data port. It never supplies an address. An internal pointer picks the target register. A control write loads a 2-bit subset code and a 2-bit read-select code, and it places the pointer on the first register of the chosen subset. Each data access then goes to the register under the pointer, and the pointer steps through the subset and wraps back to its start after the last register.

Data moves as a full word or as two bytes. In byte mode the pointer steps only after the high byte, so the host sends the low byte first. Reads are accepted only while read-select is set to the calibration code. In that state a host write is refused and raises a sticky error. A calibration engine can load any register directly through a separate indexed load port. A host may stop a sequence at any point, and the next control write starts a new sequence.

Top module: `cal_bank`

## Requirements
- R1: Register index 0 is gain, index 1 is offset and index 2+k is DAC word k+1 (k = 0..7). With subset code 00 the pointer visits indices 0,1,2,...,9 and then wraps to 0.
- R2: With subset code 01 the pointer alternates between gain (0) and offset (1), starting on gain.
- R3: Subset code 10 keeps the pointer on offset for every access. Subset code 11 keeps it on gain.
- R4: A control write (ctl_we) loads ctl_sel and ctl_rdsel and moves the pointer to the first register of the new subset, including when the previous sequence was not finished. The first register is offset for code 10 and gain for every other code.
- R5: A word-mode write (byte_mode = 0) stores wdata[13:0] and ignores wdata[15:14]. A word-mode read drives rdata = {2'b00, stored word} with rvalid high in the cycle after the accepted read strobe. Each complete access advances the pointer.
- R6: In byte mode the byte travels on bit positions [7:0] of wdata and rdata. A low-byte access (hi_byte = 0) covers stored bits [7:0] and leaves the pointer where it is. A high-byte access (hi_byte = 1) covers stored bits [13:8], taken from or returned on bits [5:0], and then advances the pointer. A low-byte read returns {8'b0, bits[7:0]}. A high-byte read returns {10'b0, bits[13:8]}.
- R7: A read strobe is accepted only when the stored read-select equals 10. At any other value it produces no rvalid and leaves the pointer unchanged.
- R8: A write strobe while the stored read-select equals 10 changes no register and does not move the pointer. It sets err, which stays high until reset.
- R9: An engine load (eng_we) writes eng_data into the register at eng_idx and never moves the pointer. A host write in the same cycle is dropped and does not advance the pointer.
- R10: After reset, rdata = 0, rvalid = 0 and err = 0. The subset code is 00 and read-select is 00, so the pointer is on gain and host writes are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_sel | input | 2 | Subset code loaded by a control write |
| ctl_rdsel | input | 2 | Read-select code loaded by a control write |
| dat_we | input | 1 | Host data write strobe |
| dat_re | input | 1 | Host data read strobe |
| byte_mode | input | 1 | 1 = byte access, 0 = full-word access |
| hi_byte | input | 1 | High-byte enable in byte mode |
| wdata | input | 16 | Host write data |
| eng_we | input | 1 | Engine load strobe |
| eng_idx | input | 4 | Engine load register index |
| eng_data | input | 14 | Engine load value |
| rdata | output | 16 | Registered read data |
| rvalid | output | 1 | High for one cycle when rdata holds a new read |
| err | output | 1 | Sticky write-during-read error |

## Verification
The assertions assume that a control write never shares a cycle with a data strobe. They also assume that the host holds byte_mode and hi_byte steady while a strobe is high. The stimulus meets both: each task raises exactly one kind of strobe for exactly one cycle. The only exception is the engine-collision case, which deliberately raises eng_we and dat_we together. The bench also never reads a register in the cycle an engine load writes it, because the result of that overlap is left undefined.

// File: rtl/cal_bank_pkg.sv
package cal_bank_pkg;
  localparam int NREG = 10;
  localparam int DW   = 14;
  localparam int BW   = 16;
  localparam int BYW  = 8;
  localparam int HIW  = DW - BYW;
  localparam int IW   = $clog2(NREG);

  typedef enum logic [1:0] {
    SEL_ALL  = 2'b00,
    SEL_PAIR = 2'b01,
    SEL_OFF  = 2'b10,
    SEL_GAIN = 2'b11
  } sel_e;

  localparam logic [1:0] RD_CAL = 2'b10;
  localparam logic [IW-1:0] IDX_GAIN = IW'(0);
  localparam logic [IW-1:0] IDX_OFF  = IW'(1);

  function automatic logic [IW-1:0] seq_first(sel_e s);
    return (s == SEL_OFF) ? IDX_OFF : IDX_GAIN;
  endfunction

  function automatic logic [IW-1:0] seq_last(sel_e s);
    case (s)
      SEL_ALL:  return IW'(NREG - 1);
      SEL_PAIR: return IDX_OFF;
      SEL_OFF:  return IDX_OFF;
      default:  return IDX_GAIN;
    endcase
  endfunction
endpackage

// File: rtl/cal_ptr.sv
module cal_ptr
  import cal_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [1:0]    ctl_sel,
  input  logic [1:0]    ctl_rdsel,
  input  logic          adv,
  output logic [IW-1:0] ptr,
  output logic [1:0]    sel_q,
  output logic [1:0]    rdsel_q
);
  logic [IW-1:0] first_cur, last_cur, first_new;

  always_comb begin
    first_cur = seq_first(sel_e'(sel_q));
    last_cur  = seq_last(sel_e'(sel_q));
    first_new = seq_first(sel_e'(ctl_sel));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= IDX_GAIN;
      sel_q   <= SEL_ALL;
      rdsel_q <= 2'b00;
    end else if (ctl_we) begin
      ptr     <= first_new;
      sel_q   <= ctl_sel;
      rdsel_q <= ctl_rdsel;
    end else if (adv) begin
      ptr <= (ptr == last_cur) ? first_cur : ptr + IW'(1);
    end
  end
endmodule

// File: rtl/cal_host.sv
module cal_host
  import cal_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we,
  input  logic       dat_we,
  input  logic       dat_re,
  input  logic       byte_mode,
  input  logic       hi_byte,
  input  logic       eng_we,
  input  logic [1:0] rdsel_q,
  output logic       host_lo,
  output logic       host_hi,
  output logic       rd_en,
  output logic       adv,
  output logic       err
);
  logic rd_mode, wr_ok, completes;

  always_comb begin
    rd_mode   = (rdsel_q == RD_CAL);
    wr_ok     = dat_we && !rd_mode && !eng_we && !ctl_we;
    completes = !byte_mode || hi_byte;
    host_lo   = wr_ok && (!byte_mode || !hi_byte);
    host_hi   = wr_ok && completes;
    rd_en     = dat_re && rd_mode && !ctl_we;
    adv       = (wr_ok || rd_en) && completes;
  end

  always_ff @(posedge clk) begin
    if (rst)
      err <= 1'b0;
    else if (dat_we && rd_mode && !ctl_we)
      err <= 1'b1;
  end
endmodule

// File: rtl/cal_store.sv
module cal_store #(
  parameter int NREG = 10,
  parameter int DW   = 14,
  parameter int BW   = 16,
  parameter int BYW  = 8,
  localparam int HIW = DW - BYW,
  localparam int IW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [IW-1:0]  waddr,
  input  logic [BYW-1:0] wlo,
  input  logic [HIW-1:0] whi,
  input  logic           rd_en,
  input  logic [IW-1:0]  raddr,
  input  logic           rd_byte,
  input  logic           rd_hi,
  output logic [BW-1:0]  rdata,
  output logic           rvalid
);
  logic [BYW-1:0] lo_mem [NREG];
  logic [HIW-1:0] hi_mem [NREG];
  logic           in_range;

  assign in_range = (int'(waddr) < NREG);

  always_ff @(posedge clk) begin
    if (wr_lo && in_range) lo_mem[waddr] <= wlo;
  end

  always_ff @(posedge clk) begin
    if (wr_hi && in_range) hi_mem[waddr] <= whi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        if (!rd_byte)
          rdata <= {{(BW-DW){1'b0}}, hi_mem[raddr], lo_mem[raddr]};
        else if (rd_hi)
          rdata <= {{(BW-HIW){1'b0}}, hi_mem[raddr]};
        else
          rdata <= {{(BW-BYW){1'b0}}, lo_mem[raddr]};
      end
    end
  end
endmodule

// File: rtl/cal_bank.sv
module cal_bank
  import cal_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [1:0]    ctl_sel,
  input  logic [1:0]    ctl_rdsel,
  input  logic          dat_we,
  input  logic          dat_re,
  input  logic          byte_mode,
  input  logic          hi_byte,
  input  logic [BW-1:0] wdata,
  input  logic          eng_we,
  input  logic [IW-1:0] eng_idx,
  input  logic [DW-1:0] eng_data,
  output logic [BW-1:0] rdata,
  output logic          rvalid,
  output logic          err
);
  logic [IW-1:0]  ptr, waddr;
  logic [1:0]     sel_q, rdsel_q;
  logic           host_lo, host_hi, rd_en, adv;
  logic           wr_lo, wr_hi;
  logic [BYW-1:0] wlo;
  logic [HIW-1:0] whi;
  logic           unused_top;

  assign unused_top = ^wdata[BW-1:DW];

  cal_ptr u_ptr (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
    .ctl_rdsel(ctl_rdsel), .adv(adv), .ptr(ptr), .sel_q(sel_q),
    .rdsel_q(rdsel_q)
  );

  cal_host u_host (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .dat_we(dat_we),
    .dat_re(dat_re), .byte_mode(byte_mode), .hi_byte(hi_byte),
    .eng_we(eng_we), .rdsel_q(rdsel_q), .host_lo(host_lo),
    .host_hi(host_hi), .rd_en(rd_en), .adv(adv), .err(err)
  );

  always_comb begin
    wr_lo = eng_we || host_lo;
    wr_hi = eng_we || host_hi;
    waddr = eng_we ? eng_idx : ptr;
    wlo   = eng_we ? eng_data[BYW-1:0] : wdata[BYW-1:0];
    if (eng_we)         whi = eng_data[DW-1:BYW];
    else if (byte_mode) whi = wdata[HIW-1:0];
    else                whi = wdata[DW-1:BYW];
  end

  cal_store #(.NREG(NREG), .DW(DW), .BW(BW), .BYW(BYW)) u_store (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .waddr(waddr),
    .wlo(wlo), .whi(whi), .rd_en(rd_en), .raddr(ptr),
    .rd_byte(byte_mode), .rd_hi(hi_byte), .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/cal_bank_chk.sv
module cal_bank_chk
  import cal_bank_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          ctl_we,
  input logic [1:0]    ctl_sel,
  input logic          dat_we,
  input logic          dat_re,
  input logic          byte_mode,
  input logic          hi_byte,
  input logic          eng_we,
  input logic [BW-1:0] rdata,
  input logic          rvalid,
  input logic          err,
  input logic [IW-1:0] ptr,
  input logic [1:0]    sel_q,
  input logic [1:0]    rdsel_q
);
  // R1
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(ptr) < NREG);

  // R3
  off_only_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == 2'b10) |-> (ptr == IDX_OFF));

  // R3
  gain_only_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == 2'b11) |-> (ptr == IDX_GAIN));

  // R2
  pair_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == 2'b01) |-> (ptr <= IDX_OFF));

  // R4
  ctl_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_sel != 2'b10) |=> (ptr == IDX_GAIN));

  // R4
  ctl_restart_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_sel == 2'b10) |=> (ptr == IDX_OFF));

  // R5
  zero_pad_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (rdata[BW-1:DW] == '0));

  // R6
  low_byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_mode && !hi_byte && !ctl_we) |=> $stable(ptr));

  // R7
  read_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_re && rdsel_q != 2'b10 && !ctl_we) |=> (!rvalid && $stable(ptr)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_we && rdsel_q == 2'b10 && !ctl_we) |=> err);

  // R9
  eng_no_move_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_we && !ctl_we && !dat_re) |=> $stable(ptr));
endmodule

bind cal_bank cal_bank_chk u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
  .dat_we(dat_we), .dat_re(dat_re), .byte_mode(byte_mode),
  .hi_byte(hi_byte), .eng_we(eng_we), .rdata(rdata), .rvalid(rvalid),
  .err(err), .ptr(ptr), .sel_q(sel_q), .rdsel_q(rdsel_q)
);

// File: tb/cal_bank_test.sv
`timescale 1ns/1ps
module cal_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_sel = 2'b00, ctl_rdsel = 2'b00;
  logic        dat_we = 1'b0, dat_re = 1'b0, byte_mode = 1'b0, hi_byte = 1'b0;
  logic [15:0] wdata = '0;
  logic        eng_we = 1'b0;
  logic [3:0]  eng_idx = '0;
  logic [13:0] eng_data = '0;
  logic [15:0] rdata;
  logic        rvalid, err;

  cal_bank uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
    .ctl_rdsel(ctl_rdsel), .dat_we(dat_we), .dat_re(dat_re),
    .byte_mode(byte_mode), .hi_byte(hi_byte), .wdata(wdata),
    .eng_we(eng_we), .eng_idx(eng_idx), .eng_data(eng_data),
    .rdata(rdata), .rvalid(rvalid), .err(err)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nbad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  logic [13:0] mdl [10];
  int          m_ptr = 0;
  logic [1:0]  m_sel = 2'b00, m_rd = 2'b00;

  function automatic int first_of(logic [1:0] s);
    return (s == 2'b10) ? 1 : 0;
  endfunction
  function automatic int last_of(logic [1:0] s);
    case (s)
      2'b00: return 9;
      2'b01: return 1;
      2'b10: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic step();
    if (m_ptr == last_of(m_sel)) m_ptr = first_of(m_sel);
    else m_ptr = m_ptr + 1;
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_ctl(logic [1:0] s, logic [1:0] r);
    @(negedge clk);
    ctl_we = 1'b1; ctl_sel = s; ctl_rdsel = r;
    @(negedge clk);
    ctl_we = 1'b0;
    m_sel = s; m_rd = r; m_ptr = first_of(s);
  endtask

  task automatic wr_word(logic [15:0] v);
    @(negedge clk);
    dat_we = 1'b1; byte_mode = 1'b0; wdata = v;
    @(negedge clk);
    dat_we = 1'b0;
    if (m_rd != 2'b10) begin
      mdl[m_ptr] = v[13:0];
      step();
    end
  endtask

  task automatic wr_byte(logic hi, logic [7:0] v);
    @(negedge clk);
    dat_we = 1'b1; byte_mode = 1'b1; hi_byte = hi; wdata = {8'h00, v};
    @(negedge clk);
    dat_we = 1'b0; byte_mode = 1'b0; hi_byte = 1'b0;
    if (m_rd != 2'b10) begin
      if (hi) begin
        mdl[m_ptr][13:8] = v[5:0];
        step();
      end else begin
        mdl[m_ptr][7:0] = v;
      end
    end
  endtask

  task automatic rd(logic bm, logic hi, string tag);
    if (m_rd == 2'b10) begin
      if (!bm)     exp_q.push_back({2'b00, mdl[m_ptr]});
      else if (hi) exp_q.push_back({10'b0, mdl[m_ptr][13:8]});
      else         exp_q.push_back({8'b0, mdl[m_ptr][7:0]});
      tag_q.push_back(tag);
      if (!bm || hi) step();
    end
    @(negedge clk);
    dat_re = 1'b1; byte_mode = bm; hi_byte = hi;
    @(negedge clk);
    dat_re = 1'b0; byte_mode = 1'b0; hi_byte = 1'b0;
  endtask

  task automatic eng_load(logic [3:0] idx, logic [13:0] v, logic with_host,
                          logic [15:0] hv);
    @(negedge clk);
    eng_we = 1'b1; eng_idx = idx; eng_data = v;
    dat_we = with_host; byte_mode = 1'b0; wdata = hv;
    @(negedge clk);
    eng_we = 1'b0; dat_we = 1'b0;
    mdl[idx] = v;
  endtask

  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) begin
        nchk++; nbad++;
        $display("FAIL R7: unexpected rvalid, got %h expected none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    nchk++; nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 rdata", rdata, 16'h0000);
    check("R10 rvalid", {15'b0, rvalid}, 16'h0000);
    check("R10 err", {15'b0, err}, 16'h0000);

    // R10 / R1 / R5: writes straight after reset land from gain onward
    for (int k = 0; k < 10; k++) wr_word(16'hC000 | 16'(k * 16'h0457 + 16'h0123));
    do_ctl(2'b00, 2'b10);
    for (int k = 0; k < 12; k++) rd(1'b0, 1'b0, "R1 full sequence");

    // R2
    do_ctl(2'b01, 2'b00);
    wr_word(16'h1A5A); wr_word(16'h2B6B);
    do_ctl(2'b01, 2'b10);
    for (int k = 0; k < 3; k++) rd(1'b0, 1'b0, "R2 pair sequence");

    // R3
    do_ctl(2'b10, 2'b00);
    wr_word(16'h0F0F); wr_word(16'h3333);
    do_ctl(2'b10, 2'b10);
    rd(1'b0, 1'b0, "R3 offset only"); rd(1'b0, 1'b0, "R3 offset only");
    do_ctl(2'b11, 2'b00);
    wr_word(16'h2222); wr_word(16'h1111);
    do_ctl(2'b11, 2'b10);
    rd(1'b0, 1'b0, "R3 gain only"); rd(1'b0, 1'b0, "R3 gain only");

    // R4: abandon a sequence mid-way
    do_ctl(2'b00, 2'b10);
    for (int k = 0; k < 3; k++) rd(1'b0, 1'b0, "R4 before abandon");
    do_ctl(2'b00, 2'b10);
    rd(1'b0, 1'b0, "R4 restart at gain");
    do_ctl(2'b00, 2'b00);
    wr_word(16'h0AAA); wr_word(16'h0BBB);
    do_ctl(2'b10, 2'b00);
    wr_word(16'h0CCC);
    do_ctl(2'b00, 2'b10);
    rd(1'b0, 1'b0, "R4 gain kept"); rd(1'b0, 1'b0, "R4 offset rewritten");

    // R6: byte mode
    do_ctl(2'b00, 2'b00);
    wr_byte(1'b0, 8'h55); wr_byte(1'b0, 8'hAB); wr_byte(1'b1, 8'h3F);
    wr_byte(1'b0, 8'h12); wr_byte(1'b1, 8'h05);
    do_ctl(2'b00, 2'b10);
    rd(1'b1, 1'b0, "R6 gain low byte"); rd(1'b1, 1'b1, "R6 gain high byte");
    rd(1'b1, 1'b0, "R6 offset low byte"); rd(1'b1, 1'b1, "R6 offset high byte");
    rd(1'b0, 1'b0, "R6 word after bytes");

    // R7: reads refused outside read-select 10
    do_ctl(2'b00, 2'b01);
    rd(1'b0, 1'b0, "R7 ignored"); rd(1'b0, 1'b0, "R7 ignored");
    wr_word(16'h1357);
    do_ctl(2'b00, 2'b10);
    rd(1'b0, 1'b0, "R7 pointer unmoved");

    // R8: write during read mode
    check("R8 err before", {15'b0, err}, 16'h0000);
    do_ctl(2'b00, 2'b10);
    wr_word(16'h3FFF);
    @(negedge clk);
    check("R8 err set", {15'b0, err}, 16'h0001);
    rd(1'b0, 1'b0, "R8 gain unchanged");
    do_ctl(2'b01, 2'b00);
    @(negedge clk);
    check("R8 err sticky", {15'b0, err}, 16'h0001);

    // R9: engine loads
    do_ctl(2'b00, 2'b00);
    eng_load(4'd5, 14'h2468, 1'b0, 16'h0000);
    eng_load(4'd3, 14'h1BCD, 1'b1, 16'h0777);
    wr_word(16'h0999);
    do_ctl(2'b00, 2'b10);
    for (int k = 0; k < 10; k++) rd(1'b0, 1'b0, "R9 engine and host");

    repeat (3) @(negedge clk);
    check("R5 all reads returned", 16'(exp_q.size()), 16'h0000);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule